// File: doc/BRIEF.md
# In-Order Commit Tracker

This block keeps a circular table of in-flight instructions. Dispatch fills the table in program order at the tail. Each entry records an instruction class and its progress through issue, execute, memory and bus-write. When an entry has finished its last stage it is marked ready to retire. A head pointer retires the oldest entry, one entry at most per cycle, and only when that entry is ready. A younger entry that is ready waits behind an older entry that is not.

The block also controls when a store may enter its memory stage. A store may execute, which means compute its address, once its address operand is known. Its memory access, however, waits until the instruction that produces the value to be stored has retired. Dependency release uses registered state only. A retirement in one cycle frees the waiting store on the following cycle, so no entry sees another entry's update within the same cycle. The block tracks tags and stages only; it holds no data or register values.

Top module: `ctrk_commit_tracker`

## Requirements
- R1: After reset the table is empty: `full` is 0, `commit_valid` is 0 and `alloc_tag` is 0.
- R2: Each accepted allocation takes tag `alloc_tag`, and the tail then advances by one modulo DEPTH (default 16). `full` is 1 while DEPTH entries are live. An allocation request while `full` is 1 is refused and leaves `alloc_tag` unchanged.
- R3: Retirement follows allocation order. At most one entry retires per cycle: `commit_valid` is 1 with `commit_tag` equal to the head tag, and the head then advances by one.
- R4: An ALU entry (kind 0) advances to executed on `exec_valid`. It becomes ready on `wb_valid`, and retires in the cycle after that strobe at the earliest.
- R5: A branch entry (kind 3) becomes ready directly on `exec_valid`, with no memory or write stage. It retires in the next cycle at the earliest.
- R6: A load entry (kind 1) moves from executed to memory when `mem_grant` is 1. It becomes ready on a later `wb_valid`.
- R7: A store entry (kind 2) becomes ready directly when `mem_grant` is 1, with no write stage.
- R8: A store allocated with `alloc_dep_valid`=1 whose producer tag `alloc_dep_tag` is still live gets `mem_grant`=0. This holds until the producer retires, and the grant is first possible in the cycle after that retirement.
- R9: A stage strobe is ignored when its tag is not live or the entry is not in the stage that the strobe completes, for example `wb_valid` for a load that is still in the executed state.
- R10: A ready entry does not retire while any older entry is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a new entry |
| alloc_kind | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| alloc_dep_valid | input | 1 | New store depends on a producer for its data |
| alloc_dep_tag | input | TAG_W | Tag of that producer |
| alloc_tag | output | TAG_W | Tag the next allocation receives (tail) |
| full | output | 1 | Table holds DEPTH live entries |
| exec_valid | input | 1 | Execute stage finished for `exec_tag` |
| exec_tag | input | TAG_W | Tag finishing execute |
| mem_req_valid | input | 1 | Memory unit asks to start `mem_req_tag` |
| mem_req_tag | input | TAG_W | Tag requesting memory |
| mem_grant | output | 1 | Memory stage entered this cycle |
| wb_valid | input | 1 | Result of `wb_tag` driven on the bus |
| wb_tag | input | TAG_W | Tag writing its result |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring entry |

## Verification
The assertions assume that dispatch never names a producer tag younger than the store itself. They also assume that each stage strobe carries a single tag per cycle. The stimulus allocates producers before their consumers and drives at most one strobe of each type per cycle. The bench still sends strobes to dead tags and to entries in the wrong stage, to show that such strobes are ignored.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;
  typedef enum logic [1:0] {K_ALU = 2'd0, K_LOAD = 2'd1, K_STORE = 2'd2, K_BRANCH = 2'd3} kind_e;
  typedef enum logic [1:0] {S_ISSUED = 2'd0, S_EXECUTED = 2'd1, S_MEM = 2'd2, S_READY = 2'd3} stage_e;

  // Stage reached when execute finishes
  function automatic stage_e after_exec(kind_e k);
    return (k == K_BRANCH) ? S_READY : S_EXECUTED;
  endfunction

  // Stage reached when the memory stage is entered
  function automatic stage_e after_mem(kind_e k);
    return (k == K_STORE) ? S_READY : S_MEM;
  endfunction

  function automatic logic uses_mem(kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

  // A bus write is meaningful only from these positions
  function automatic logic bus_write_ok(kind_e k, stage_e s);
    return ((k == K_ALU) && (s == S_EXECUTED)) || ((k == K_LOAD) && (s == S_MEM));
  endfunction
endpackage

// File: rtl/ctrk_ptrs.sv
module ctrk_ptrs #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full
);
  logic [CNT_W-1:0] count;

  function automatic logic [TAG_W-1:0] step(logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= step(tail);
      if (commit_fire) head <= step(head);
      case ({alloc_fire, commit_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> head == step($past(head)));
endmodule

// File: rtl/ctrk_slot.sv
module ctrk_slot
  import ctrk_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  kind_e            alloc_kind,
  input  logic             alloc_dep_pend,
  input  logic [TAG_W-1:0] alloc_dep_tag,
  input  logic             exec_hit,
  input  logic             mem_hit,
  input  logic             wb_hit,
  input  logic             commit_hit,
  input  logic             commit_v,
  input  logic [TAG_W-1:0] commit_tag,
  output logic             valid_o,
  output stage_e           stage_o,
  output logic             mem_ok_o
);
  logic             valid_q;
  stage_e           stage_q;
  kind_e            kind_q;
  logic             dep_pend_q;
  logic [TAG_W-1:0] dep_tag_q;
  logic             dep_release;

  // Producer retiring now; takes effect at the next edge only
  assign dep_release = commit_v && (commit_tag == dep_tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      stage_q    <= S_ISSUED;
      kind_q     <= K_ALU;
      dep_pend_q <= 1'b0;
      dep_tag_q  <= '0;
    end else if (alloc_hit) begin
      valid_q    <= 1'b1;
      stage_q    <= S_ISSUED;
      kind_q     <= alloc_kind;
      dep_pend_q <= alloc_dep_pend;
      dep_tag_q  <= alloc_dep_tag;
    end else if (valid_q) begin
      if (commit_hit) begin
        valid_q <= 1'b0;
      end else begin
        if (exec_hit && stage_q == S_ISSUED)          stage_q <= after_exec(kind_q);
        else if (mem_hit)                             stage_q <= after_mem(kind_q);
        else if (wb_hit && bus_write_ok(kind_q, stage_q)) stage_q <= S_READY;
      end
      if (dep_release) dep_pend_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign stage_o  = stage_q;
  assign mem_ok_o = valid_q && (stage_q == S_EXECUTED) && uses_mem(kind_q)
                    && !((kind_q == K_STORE) && dep_pend_q);

  // R8
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kind_q == K_STORE && mem_hit) |-> !dep_pend_q);

  // R7
  store_no_mem_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && kind_q == K_STORE && stage_q == S_MEM));

  // R5
  branch_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && kind_q == K_BRANCH && (stage_q == S_EXECUTED || stage_q == S_MEM)));

  // R4
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && stage_q == S_READY && !commit_hit) |=> (valid_q && stage_q == S_READY));

  // R9
  dead_stays_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !alloc_hit) |=> !valid_q);
endmodule

// File: rtl/ctrk_commit_tracker.sv
module ctrk_commit_tracker
  import ctrk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_kind,
  input  logic             alloc_dep_valid,
  input  logic [TAG_W-1:0] alloc_dep_tag,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             full,
  input  logic             exec_valid,
  input  logic [TAG_W-1:0] exec_tag,
  input  logic             mem_req_valid,
  input  logic [TAG_W-1:0] mem_req_tag,
  output logic             mem_grant,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             commit_valid,
  output logic [TAG_W-1:0] commit_tag
);
  logic             alloc_fire;
  logic [TAG_W-1:0] head, tail;
  logic             valid_v  [DEPTH];
  stage_e           stage_v  [DEPTH];
  logic             mem_ok_v [DEPTH];
  logic             dep_pend_new;

  assign alloc_fire   = alloc_valid && !full;
  assign alloc_tag    = tail;
  assign commit_tag   = head;
  assign commit_valid = valid_v[head] && (stage_v[head] == S_READY);
  assign mem_grant    = mem_req_valid && mem_ok_v[mem_req_tag];
  // Producer already gone, or leaving this cycle, means no hold
  assign dep_pend_new = alloc_dep_valid && valid_v[alloc_dep_tag]
                        && !(commit_valid && commit_tag == alloc_dep_tag);

  ctrk_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .commit_fire(commit_valid),
    .head(head), .tail(tail), .full(full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ctrk_slot #(.TAG_W(TAG_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_hit(alloc_fire && tail == TAG_W'(g)),
      .alloc_kind(kind_e'(alloc_kind)),
      .alloc_dep_pend(dep_pend_new),
      .alloc_dep_tag(alloc_dep_tag),
      .exec_hit(exec_valid && exec_tag == TAG_W'(g)),
      .mem_hit(mem_grant && mem_req_tag == TAG_W'(g)),
      .wb_hit(wb_valid && wb_tag == TAG_W'(g)),
      .commit_hit(commit_valid && head == TAG_W'(g)),
      .commit_v(commit_valid), .commit_tag(head),
      .valid_o(valid_v[g]), .stage_o(stage_v[g]), .mem_ok_o(mem_ok_v[g])
    );
  end

  // R3
  commit_only_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !valid_v[$past(head)] || $past(alloc_fire && tail == head));
endmodule

// File: tb/ctrk_commit_tracker_tb_top.sv
`timescale 1ns/1ps
module ctrk_commit_tracker_tb_top;
  localparam int DEPTH = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_dep_valid = 0, exec_valid = 0, mem_req_valid = 0, wb_valid = 0;
  logic [1:0] alloc_kind = 0;
  logic [TW-1:0] alloc_dep_tag = 0, exec_tag = 0, mem_req_tag = 0, wb_tag = 0;
  logic [TW-1:0] alloc_tag, commit_tag;
  logic full, mem_grant, commit_valid;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ctrk_commit_tracker #(.DEPTH(DEPTH)) dut_i (.*);

  typedef struct packed {
    logic al; logic [1:0] kd; logic dv; logic [3:0] dt;
    logic ex; logic [3:0] et; logic mr; logic [3:0] mt;
    logic wb; logic [3:0] wt; logic ec; logic [3:0] ect; logic eg;
  } vec_t;

  // kind: 0 ALU, 1 load, 2 store, 3 branch
  localparam vec_t VECS [14] = '{
    {1'b1,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0}, // alloc ALU t0
    {1'b1,2'd2,1'b1,4'd0, 1'b1,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0}, // alloc store t1 dep t0
    {1'b1,2'd3,1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0}, // alloc branch t2
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 1'b1,4'd0, 1'b0,4'd0, 1'b0}, // R8 held
    {1'b0,2'd0,1'b0,4'd0, 1'b1,4'd2, 1'b1,4'd1, 1'b0,4'd0, 1'b1,4'd0, 1'b0}, // R4 commit t0, still held
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd0, 1'b1}, // R8 grant, R10 t2 waits
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 1'b0}, // R7 store commits
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd2, 1'b0}, // R5 branch commits
    {1'b1,2'd1,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0}, // alloc load t3
    {1'b0,2'd0,1'b0,4'd0, 1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0},
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3, 1'b1,4'd3, 1'b0,4'd0, 1'b1}, // R9 early wb ignored
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3, 1'b0,4'd0, 1'b0}, // R6 wb from mem
    {1'b0,2'd0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3, 1'b0}, // R6 load commits
    {1'b0,2'd0,1'b0,4'd0, 1'b1,4'd5, 1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b0}  // R9 dead tag
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_dep_valid = 0; exec_valid = 0; mem_req_valid = 0; wb_valid = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1
    chk("R1 full", full, 0);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 alloc_tag", alloc_tag, 0);

    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      alloc_valid = VECS[i].al; alloc_kind = VECS[i].kd;
      alloc_dep_valid = VECS[i].dv; alloc_dep_tag = VECS[i].dt;
      exec_valid = VECS[i].ex; exec_tag = VECS[i].et;
      mem_req_valid = VECS[i].mr; mem_req_tag = VECS[i].mt;
      wb_valid = VECS[i].wb; wb_tag = VECS[i].wt;
      #1;
      chk("R3 commit_valid", commit_valid, VECS[i].ec);
      if (VECS[i].ec) chk("R3 commit_tag", commit_tag, VECS[i].ect);
      chk("R8 mem_grant", mem_grant, VECS[i].eg);
    end
    @(negedge clk); idle();

    // R2: fill from tag 4, wrap, then refuse
    for (int i = 0; i < DEPTH; i++) begin
      alloc_valid = 1; alloc_kind = 2'd3;
      #1;
      chk("R2 alloc_tag", alloc_tag, (4 + i) % DEPTH);
      chk("R2 not full", full, 0);
      @(negedge clk);
    end
    alloc_valid = 1; #1;
    chk("R2 full", full, 1);
    @(negedge clk); alloc_valid = 0; #1;
    chk("R2 refused tag", alloc_tag, 4);
    chk("R2 still full", full, 1);

    // R10: execute youngest first; nothing retires until the head is ready
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      exec_valid = 1; exec_tag = TW'((4 + DEPTH - 1 - i) % DEPTH);
      #1;
      chk("R10 no commit", commit_valid, 0);
    end
    @(negedge clk); idle();
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R3 in-order valid", commit_valid, 1);
      chk("R3 in-order tag", commit_tag, (4 + i) % DEPTH);
      @(negedge clk);
    end
    #1;
    chk("R3 drained", commit_valid, 0);
    chk("R2 drained not full", full, 0);

    // R1: reset with live entries
    @(negedge clk); alloc_valid = 1; alloc_kind = 2'd3;
    @(negedge clk); exec_valid = 1; exec_tag = alloc_tag - 1'b1; alloc_valid = 0;
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 reset tag", alloc_tag, 0);
    chk("R1 reset full", full, 0);
    chk("R1 reset commit", commit_valid, 0);
    @(negedge clk);
    finish_run();
  end
endmodule